// File: doc/BRIEF.md
# Phase-Frequency Detector with Delayed Reset

This block is a sampled-logic model of a tri-state phase-frequency detector. It compares a reference input with a feedback input, both sampled by a fast system clock. Each input passes through a two-flop synchroniser and a rising-edge detector. A reference edge raises the UP output and a feedback edge raises the DN output. When both outputs are high, a clear request is issued. That clear is held back for a programmable number of clock cycles, so every comparison ends with a short window in which both outputs are high together.

Because of this overlap window, the difference between the UP and DN active times equals the phase offset, down to a single sample. There is no dead zone. A signed, saturating accumulator stands in for the charge sent to a loop filter. It adds one for each cycle in which only UP is high and subtracts one for each cycle in which only DN is high.

Top module: `pfd_delayed_reset`

## Requirements
- R1: After reset, up_o and dn_o are low, net_o is 0 and no clear is pending.
- R2: A reference rising edge that is first sampled high at clock edge k sets up_o after clock edge k+2 (two synchroniser flops, then the state bit).
- R3: A feedback rising edge that is first sampled high at clock edge k sets dn_o after clock edge k+2.
- R4: Once up_o and dn_o are both high, they stay high together for exactly D cycles, where D is the value of td_i. Both then fall on the same edge.
- R5: td_i is an unsigned cycle count. A value of 0 is treated as 1.
- R6: If the feedback edge trails the reference edge by te cycles, up_o is high for te+D cycles and dn_o for D cycles, and net_o rises by te. With the order reversed, dn_o is high for te+D cycles and net_o falls by te.
- R7: A one-cycle offset changes net_o by exactly +1 or -1 (no dead zone). Edges that arrive in the same sample give equal UP and DN widths and a net change of 0.
- R8: A rising edge that arrives while a clear is pending (both outputs high, including the clearing cycle) is kept. It sets its output one cycle after both outputs have fallen.
- R9: net_o is a signed 16-bit register. It is updated one edge after the outputs it reflects: +1 when only up_o is high, -1 when only dn_o is high, otherwise unchanged.
- R10: net_o saturates at 32767 and at -32768.
- R11: acc_clr_i high at a clock edge sets net_o to 0 at that edge and takes priority over counting.
- R12: A rising edge on an input whose output is already high, while the other output is low, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Reference input, asynchronous to clk_i |
| fb_i | input | 1 | Feedback input, asynchronous to clk_i |
| td_i | input | 8 | Overlap length in cycles (0 is treated as 1) |
| acc_clr_i | input | 1 | Synchronous clear of the net accumulator |
| up_o | output | 1 | UP pulse output |
| dn_o | output | 1 | DN pulse output |
| net_o | output | 16 | Signed net pulse count (UP-only cycles minus DN-only cycles) |

## Verification
Two things can happen in the same cycle. First, a fresh input edge can land inside the delayed-clear window, including the very cycle in which the clear fires. The bench provokes this by pulsing the reference input again during a long overlap. The second rise must appear one cycle after both outputs fall. Second, both edges can land in one sample. The bench judges this by requiring equal UP and DN widths and no change in net_o. A behavioural reference model, built from sample queues and integer counters, predicts up_o, dn_o and net_o on every clock. This model also checks a clear of the accumulator that coincides with counting.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], sig_i};
  end

  // rise seen between last synchronised sample and the one before
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pfd_state_core.sv
module pfd_state_core #(
  parameter int TD_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ref_edge_i,
  input  logic            fb_edge_i,
  input  logic [TD_W-1:0] td_i,
  output logic            up_o,
  output logic            dn_o
);
  logic            up_q, dn_q, up_d, dn_d;
  logic            ref_hold_q, fb_hold_q, ref_hold_d, fb_hold_d;
  logic [TD_W-1:0] cnt_q, cnt_d, td_eff;
  logic            both, clr_now;

  assign td_eff  = (td_i == '0) ? TD_W'(1) : td_i;
  assign both    = up_q & dn_q;
  assign clr_now = both & (cnt_q >= td_eff - TD_W'(1));

  always_comb begin
    up_d       = up_q;
    dn_d       = dn_q;
    cnt_d      = '0;
    ref_hold_d = 1'b0;
    fb_hold_d  = 1'b0;
    if (both) begin
      ref_hold_d = ref_hold_q | ref_edge_i;
      fb_hold_d  = fb_hold_q | fb_edge_i;
      if (clr_now) begin
        up_d = 1'b0;
        dn_d = 1'b0;
      end else begin
        cnt_d = cnt_q + TD_W'(1);
      end
    end else begin
      up_d = up_q | ref_edge_i | ref_hold_q;
      dn_d = dn_q | fb_edge_i | fb_hold_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q       <= 1'b0;
      dn_q       <= 1'b0;
      cnt_q      <= '0;
      ref_hold_q <= 1'b0;
      fb_hold_q  <= 1'b0;
    end else begin
      up_q       <= up_d;
      dn_q       <= dn_d;
      cnt_q      <= cnt_d;
      ref_hold_q <= ref_hold_d;
      fb_hold_q  <= fb_hold_d;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;

  a_r2_ref_sets_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_edge_i && !both) |=> up_q);
  a_r3_fb_sets_dn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_edge_i && !both) |=> dn_q);
  a_r4_joint_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && dn_q) |=> (up_q == dn_q));
  a_r8_ref_hold_applied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(up_q) && ref_hold_q) |=> up_q);
  a_r8_fb_hold_applied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dn_q) && fb_hold_q) |=> dn_q);
endmodule

// File: rtl/pfd_net_acc.sv
module pfd_net_acc #(
  parameter int ACC_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    up_i,
  input  logic                    dn_i,
  output logic signed [ACC_W-1:0] acc_o
);
  import pfd_pkg::*;

  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q;
  step_e                   step;

  always_comb begin
    step = STEP_HOLD;
    if (up_i && !dn_i && acc_q != ACC_MAX) step = STEP_INC;
    if (dn_i && !up_i && acc_q != ACC_MIN) step = STEP_DEC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clr_i)   acc_q <= '0;
    else begin
      unique case (step)
        STEP_INC: acc_q <= acc_q + ACC_W'(1);
        STEP_DEC: acc_q <= acc_q - ACC_W'(1);
        default:  acc_q <= acc_q;
      endcase
    end
  end

  assign acc_o = acc_q;

  a_r9_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && up_i && !dn_i && acc_q != ACC_MAX) |=> (acc_q == $past(acc_q) + ACC_W'(1)));
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && up_i == dn_i) |=> $stable(acc_q));
  a_r10_sat_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && acc_q == ACC_MAX && !dn_i) |=> (acc_q == ACC_MAX));
  a_r10_sat_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && acc_q == ACC_MIN && !up_i) |=> (acc_q == ACC_MIN));
  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0));
endmodule

// File: rtl/pfd_delayed_reset.sv
module pfd_delayed_reset #(
  parameter int TD_W   = 8,
  parameter int ACC_W  = 16,
  parameter int STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ref_i,
  input  logic                    fb_i,
  input  logic [TD_W-1:0]         td_i,
  input  logic                    acc_clr_i,
  output logic                    up_o,
  output logic                    dn_o,
  output logic signed [ACC_W-1:0] net_o
);
  localparam int N_IN = 2;

  logic [N_IN-1:0] raw, rise;
  logic            up, dn;

  assign raw = {fb_i, ref_i};

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    pfd_edge_sync #(.STAGES(STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sig_i  (raw[g]),
      .rise_o (rise[g])
    );
  end

  pfd_state_core #(.TD_W(TD_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_edge_i (rise[0]),
    .fb_edge_i  (rise[1]),
    .td_i       (td_i),
    .up_o       (up),
    .dn_o       (dn)
  );

  pfd_net_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (acc_clr_i),
    .up_i   (up),
    .dn_i   (dn),
    .acc_o  (net_o)
  );

  assign up_o = up;
  assign dn_o = dn;

  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |=> (!up_o && !dn_o && net_o == '0));
endmodule

// File: tb/sim_pfd_delayed_reset.sv
module sim_pfd_delayed_reset;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ref_s = 1'b0, fb_s = 1'b0, clr_s = 1'b0;
  logic [7:0]        td_s = 8'd3;
  logic              up, dn;
  logic signed [15:0] net;

  int n_chk = 0, n_fail = 0;
  int up_cnt = 0, dn_cnt = 0;

  // reference model state
  bit m_up, m_dn, m_rh, m_fh;
  int m_age, m_acc;
  bit rq[$], fq[$];

  always #2.5 clk = ~clk;

  pfd_delayed_reset u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_s), .fb_i(fb_s), .td_i(td_s),
    .acc_clr_i(clr_s), .up_o(up), .dn_o(dn), .net_o(net)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_up = 0; m_dn = 0; m_rh = 0; m_fh = 0; m_age = 0; m_acc = 0;
    rq = '{0, 0, 0, 0}; fq = '{0, 0, 0, 0};
  endtask

  initial model_reset();

  // behavioural reference, evaluated at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int tde;
      bit re, fe;
      tde = (td_s == 0) ? 1 : int'(td_s);
      if (clr_s) m_acc = 0;
      else if (m_up && !m_dn && m_acc < 32767) m_acc++;
      else if (m_dn && !m_up && m_acc > -32768) m_acc--;
      rq.push_front(ref_s); void'(rq.pop_back());
      fq.push_front(fb_s);  void'(fq.pop_back());
      re = rq[2] && !rq[3];
      fe = fq[2] && !fq[3];
      if (m_up && m_dn) begin
        m_rh |= re; m_fh |= fe;
        m_age++;
        if (m_age >= tde) begin m_up = 0; m_dn = 0; m_age = 0; end
      end else begin
        m_up |= re | m_rh;
        m_dn |= fe | m_fh;
        m_rh = 0; m_fh = 0; m_age = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (up) up_cnt++;
      if (dn) dn_cnt++;
      chk(up == m_up, "R2 R12 model up_o", int'(up), int'(m_up));
      chk(dn == m_dn, "R3 R4 model dn_o", int'(dn), int'(m_dn));
      chk(int'(net) == m_acc, "R9 R10 R11 model net_o", int'(net), m_acc);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // te > 0: ref leads; te < 0: fb leads; te == 0: same sample
  task automatic compare(input int te, input int td, input string tag);
    int n0, tde, a;
    tde = (td == 0) ? 1 : td;
    a = (te < 0) ? -te : te;
    @(negedge clk); td_s = 8'(td);
    idle(10);
    n0 = int'(net); up_cnt = 0; dn_cnt = 0;
    if (te >= 0) ref_s = 1'b1; else fb_s = 1'b1;
    idle(a);
    ref_s = 1'b1; fb_s = 1'b1;
    idle(tde + a + 12);
    chk(up_cnt == ((te > 0) ? te + tde : tde), {tag, " up width"}, up_cnt, (te > 0) ? te + tde : tde);
    chk(dn_cnt == ((te < 0) ? a + tde : tde), {tag, " dn width"}, dn_cnt, (te < 0) ? a + tde : tde);
    chk(int'(net) - n0 == te, {tag, " net change"}, int'(net) - n0, te);
    ref_s = 1'b0; fb_s = 1'b0;
    idle(6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(up == 0 && dn == 0, "R1 outputs low in reset", int'({up, dn}), 0);
    chk(net == 0, "R1 net zero in reset", int'(net), 0);
    rst_n = 1'b1;
    idle(3);
    chk(up == 0 && dn == 0 && net == 0, "R1 idle after reset", int'({up, dn}), 0);

    // R2 latency: ref sampled high at edge k, up high after edge k+2
    ref_s = 1'b1;
    @(negedge clk); chk(up == 0, "R2 not yet after k", int'(up), 0);
    @(negedge clk); chk(up == 0, "R2 not yet after k+1", int'(up), 0);
    @(negedge clk); chk(up == 1, "R2 up after k+2", int'(up), 1);
    // R3 latency
    fb_s = 1'b1;
    @(negedge clk); @(negedge clk); chk(dn == 0, "R3 not yet after k+1", int'(dn), 0);
    @(negedge clk); chk(dn == 1, "R3 dn after k+2", int'(dn), 1);
    ref_s = 1'b0; fb_s = 1'b0;
    idle(10);

    compare(4, 3, "R4 R6 ref lead 4 td 3");
    compare(-5, 6, "R6 fb lead 5 td 6");
    compare(1, 2, "R7 one-cycle ref lead");
    compare(-1, 2, "R7 one-cycle fb lead");
    compare(0, 4, "R7 same sample");
    compare(3, 0, "R5 td zero as one");
    compare(2, 255, "R4 td max");

    // R12: second ref edge while only UP is high
    @(negedge clk); td_s = 8'd2; up_cnt = 0; dn_cnt = 0;
    ref_s = 1'b1; idle(3); ref_s = 1'b0; idle(2); ref_s = 1'b1; idle(3);
    fb_s = 1'b1; idle(20);
    chk(up_cnt == 10, "R12 repeated ref edge ignored", up_cnt, 10);
    ref_s = 1'b0; fb_s = 1'b0; idle(6);

    // R8: ref edge inside the overlap window is held
    @(negedge clk); td_s = 8'd8;
    ref_s = 1'b1; idle(1); fb_s = 1'b1; idle(4);
    ref_s = 1'b0; idle(1); ref_s = 1'b1; idle(20);
    chk(up == 1 && dn == 0, "R8 held ref edge sets up", int'({up, dn}), 2);
    fb_s = 1'b0; idle(2); fb_s = 1'b1; idle(20);
    chk(up == 0 && dn == 0, "R8 released after clear", int'({up, dn}), 0);
    ref_s = 1'b0; fb_s = 1'b0; idle(6);

    // R11: clear while counting
    @(negedge clk); clr_s = 1'b1; @(negedge clk); clr_s = 1'b0;
    chk(net == 0, "R11 clear", int'(net), 0);
    ref_s = 1'b1; idle(10); clr_s = 1'b1; @(negedge clk); clr_s = 1'b0;
    chk(net == 0, "R11 clear beats increment", int'(net), 0);

    // R10 positive saturation (UP still high)
    idle(33000);
    chk(int'(net) == 32767, "R10 saturate high", int'(net), 32767);
    fb_s = 1'b1; idle(10); ref_s = 1'b0; fb_s = 1'b0; idle(6);
    chk(int'(net) == 32767, "R10 held at max", int'(net), 32767);
    // R10 negative saturation
    fb_s = 1'b1; idle(66000);
    chk(int'(net) == -32768, "R10 saturate low", int'(net), -32768);
    ref_s = 1'b1; idle(10); ref_s = 1'b0; fb_s = 1'b0; idle(6);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule